// File: doc/BRIEF.md
# Parallel Bus Master Transfer Sequencer

This block runs single memory or I/O transfers as master on an asynchronous, handshake-completed parallel backplane. The backplane has 24 address lines and 16 data lines, all active low. A local requester hands over one transfer at a time. Each transfer carries an address, write data, a width (8 or 16 bit), a space (memory or I/O), a direction and a lock flag. The sequencer then works through the bus phases in order. It drives the address, the width line and any write data, and holds them for a fixed setup time. It then asserts one of four command strobes and keeps it asserted until the slave acknowledges. After that it releases the strobe and waits for the acknowledge to go away before it accepts new work.

Completion comes only from the slave acknowledge. That input is synchronized, so its timing relative to the local clock does not matter. A transfer that is never acknowledged ends with an error once the timeout expires; the timeout is sized to at least one millisecond. A run of transfers can hold the shared bus lock so that a read and its following write form one atomic read-modify-write. The lock has a hard upper limit on how long it stays asserted. When that limit is reached the lock is dropped by force, and any transfer still in flight ends with an error.

The request side is a valid/ready stream. The requester holds `req_valid` and every request field stable until it sees `req_ready` high at a rising clock edge. That edge accepts the request. `req_ready` is high only while the sequencer is idle. Back-pressure therefore lasts for a whole transfer, including acknowledge recovery and lock hold. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse, and the consumer must take `rsp_rdata` and `rsp_err` in that cycle.

Top module: `bus_xfer_master`

## Requirements
- R1: While reset is held and right after it, every active-low bus output is high. This covers all address and data lines, the width line, the four strobes and the lock line. `bus_adr_oe` and `bus_dat_oe` are 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: From the accepting edge, `bus_adr_oe` is 1 and each address line carries the inverse of its request bit. This holds until the command is released. The strobe asserts after exactly SETUP_CYC cycles of address-only drive, and the address does not change while the strobe is asserted.
- R3: Exactly one strobe is asserted per transfer. The strobe is chosen by the pair {io, write}: 00 gives memory read (`bus_mrd_n`), 01 memory write (`bus_mwr_n`), 10 I/O read (`bus_ior_n`) and 11 I/O write (`bus_iow_n`). No two strobes are ever low together.
- R4: For a 16-bit transfer (wide=1), `bus_bhe_n` is low and all 16 data lines carry the inverted data. For an 8-bit transfer, `bus_bhe_n` stays high and write data goes only on lines 7..0, with lines 15..8 left high. An 8-bit read returns zeros in `rsp_rdata[15:8]`.
- R5: The strobe stays asserted until a synchronized low on `bus_ack_n`. The sequencer then captures the read data as the inverse of `bus_dat_in_n`. It releases the strobe and gives a one-cycle `rsp_valid` with `rsp_err`=0.
- R6: A request is accepted only on an edge where both `req_valid` and `req_ready` are high. `req_ready` stays 0 from acceptance until `bus_ack_n` has returned high after the command. `rsp_valid` never lasts more than one cycle.
- R7: If no acknowledge arrives, the strobe is released after exactly TIMEOUT_CYC cycles and the response carries `rsp_err`=1. The default, 50000 cycles of a 50 MHz clock, is 1 ms.
- R8: A request with lock=1 drives `bus_lock_n` low from its accepting edge, before its strobe asserts. The lock stays low after that transfer completes, and across further transfers, as long as it is not released.
- R9: A transfer accepted with lock=0 while the lock is held is the last locked cycle. It runs under the lock, and `bus_lock_n` returns high no sooner than HOLD_CYC cycles after its strobe is released.
- R10: `bus_lock_n` is never low for more than LOCK_MAX_CYC consecutive cycles. When that limit is reached, the lock is released and `lock_abort` pulses for one cycle. A transfer still in setup or command phase is ended, and its response carries `rsp_err`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready (idle) |
| req_addr | input | 24 | Transfer address |
| req_wdata | input | 16 | Write data (low byte only for 8-bit) |
| req_wide | input | 1 | 1 = 16-bit transfer, 0 = 8-bit |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lock | input | 1 | 1 = keep the bus lock after this transfer |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 16 | Read data (true polarity) |
| rsp_err | output | 1 | Timeout or lock-limit abort |
| lock_abort | output | 1 | One-cycle pulse when the lock limit forced release |
| bus_adr_n | output | 24 | Active-low address lines |
| bus_adr_oe | output | 1 | Address and width line driver enable |
| bus_bhe_n | output | 1 | Active-low high-byte enable (16-bit transfer) |
| bus_dat_out_n | output | 16 | Active-low write data lines |
| bus_dat_oe | output | 1 | Data line driver enable |
| bus_dat_in_n | input | 16 | Active-low read data lines |
| bus_mrd_n | output | 1 | Memory read strobe |
| bus_mwr_n | output | 1 | Memory write strobe |
| bus_ior_n | output | 1 | I/O read strobe |
| bus_iow_n | output | 1 | I/O write strobe |
| bus_ack_n | input | 1 | Active-low slave acknowledge (asynchronous) |
| bus_lock_n | output | 1 | Active-low bus lock |

## Verification
The bench counts the cycles of address-only drive before each strobe. A sequencer that asserted the command one cycle early would break the setup margin, and one that ran late would waste bandwidth; either shows up as a count other than SETUP_CYC. It also checks 8-bit reads where the slave drives all 16 lines. A design that forgot the lane mask would return garbage in the upper byte. A slave that holds its acknowledge after the command is released exposes a sequencer that starts the next cycle into a stale acknowledge. The lock cases cover three things: the tail hold after the last locked write, the limit reached while idle, and the limit reached during a stuck transfer. A wrong counter bound or a missing abort path would leave the lock asserted past LOCK_MAX_CYC, or would leave a transfer with no error response.

// File: rtl/bxm_pkg.sv
package bxm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CMD,
    ST_RECOVER,
    ST_HOLD
  } bxm_state_e;

  localparam int STROBE_N = 4;
  localparam int SI_MRD   = 0;
  localparam int SI_MWR   = 1;
  localparam int SI_IOR   = 2;
  localparam int SI_IOW   = 3;

  // one-hot, active-high strobe selection from {io, write}
  function automatic logic [STROBE_N-1:0] strobe_sel(input logic io, input logic wr);
    logic [STROBE_N-1:0] s;
    s = '0;
    s[{io, wr}] = 1'b1;
    return s;
  endfunction

endpackage

// File: rtl/bxm_sync.sv
module bxm_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= {W{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/bxm_down_timer.sv
module bxm_down_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/bxm_lock_window.sv
module bxm_lock_window #(
  parameter int LOCK_MAX_CYC = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic lock_o,
  output logic expire_o,
  output logic abort_o
);
  localparam int LW = $clog2(LOCK_MAX_CYC + 1);

  logic [LW-1:0] cnt;
  logic          drop;

  assign expire_o = lock_o && !clr_i && (cnt == LW'(LOCK_MAX_CYC - 1));
  assign drop     = expire_o || clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_o  <= 1'b0;
      cnt     <= '0;
      abort_o <= 1'b0;
    end else begin
      abort_o <= expire_o;
      if (drop)       lock_o <= 1'b0;
      else if (set_i) lock_o <= 1'b1;
      if (lock_o && !drop) cnt <= cnt + 1'b1;
      else                 cnt <= '0;
    end
  end
endmodule

// File: rtl/bus_xfer_master.sv
module bus_xfer_master
  import bxm_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int DATA_W       = 16,
  parameter int SETUP_CYC    = 3,
  parameter int HOLD_CYC     = 5,
  parameter int TIMEOUT_CYC  = 50000,
  parameter int LOCK_MAX_CYC = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_wide,
  input  logic              req_io,
  input  logic              req_write,
  input  logic              req_lock,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              lock_abort,
  output logic [ADDR_W-1:0] bus_adr_n,
  output logic              bus_adr_oe,
  output logic              bus_bhe_n,
  output logic [DATA_W-1:0] bus_dat_out_n,
  output logic              bus_dat_oe,
  input  logic [DATA_W-1:0] bus_dat_in_n,
  output logic              bus_mrd_n,
  output logic              bus_mwr_n,
  output logic              bus_ior_n,
  output logic              bus_iow_n,
  input  logic              bus_ack_n,
  output logic              bus_lock_n
);
  localparam int LANE_W = DATA_W / 2;
  localparam int PH_MAX = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int TO_W   = $clog2(TIMEOUT_CYC + 1);

  bxm_state_e state, state_n;

  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic              cur_wide, cur_io, cur_write, cur_lock;

  logic              accept;
  logic              ack_n_s, ack_s;
  logic              ph_load, ph_dec, ph_zero;
  logic [PH_W-1:0]   ph_val;
  logic              to_zero;
  logic              lk_set, lk_clr, lk_on, lk_expire;
  logic              rsp_fire, rsp_err_n;
  logic              drive, cmd_on;
  logic [DATA_W-1:0] rd_true, wd_lanes;
  logic [STROBE_N-1:0] sel, strobe_n;

  // acknowledge crosses from the bus domain
  bxm_sync #(.W(1), .STAGES(2), .RST_VAL(1'b1)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_ack_n), .q(ack_n_s)
  );
  assign ack_s = !ack_n_s;

  // setup and lock-tail phase counter
  bxm_down_timer #(.W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val),
    .dec(ph_dec), .zero(ph_zero)
  );

  // acknowledge timeout, reloaded whenever the strobe is not asserted
  bxm_down_timer #(.W(TO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .load(state != ST_CMD),
    .load_val(TO_W'(TIMEOUT_CYC - 1)),
    .dec(state == ST_CMD), .zero(to_zero)
  );

  bxm_lock_window #(.LOCK_MAX_CYC(LOCK_MAX_CYC)) u_lockwin (
    .clk(clk), .rst_n(rst_n), .set_i(lk_set), .clr_i(lk_clr),
    .lock_o(lk_on), .expire_o(lk_expire), .abort_o(lock_abort)
  );

  assign req_ready = (state == ST_IDLE) && !lk_expire;
  assign accept    = req_valid && req_ready;
  assign lk_set    = accept && req_lock;
  assign lk_clr    = (state == ST_HOLD) && ph_zero;

  // read data, masked to the low lane for narrow transfers
  assign rd_true = cur_wide ? ~bus_dat_in_n
                            : {{(DATA_W-LANE_W){1'b0}}, ~bus_dat_in_n[LANE_W-1:0]};

  always_comb begin
    state_n   = state;
    ph_load   = 1'b0;
    ph_val    = PH_W'(SETUP_CYC - 1);
    rsp_fire  = 1'b0;
    rsp_err_n = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          state_n = ST_SETUP;
          ph_load = 1'b1;
        end
      end
      ST_SETUP: begin
        if (lk_expire) begin
          state_n   = ST_RECOVER;
          rsp_fire  = 1'b1;
          rsp_err_n = 1'b1;
        end else if (ph_zero) begin
          state_n = ST_CMD;
        end
      end
      ST_CMD: begin
        if (lk_expire || ack_s || to_zero) begin
          state_n   = ST_RECOVER;
          rsp_fire  = 1'b1;
          rsp_err_n = lk_expire || !ack_s;
        end
      end
      ST_RECOVER: begin
        if (!ack_s) begin
          if (lk_on && !cur_lock) begin
            state_n = ST_HOLD;
            ph_load = 1'b1;
            ph_val  = PH_W'(HOLD_CYC - 1);
          end else begin
            state_n = ST_IDLE;
          end
        end
      end
      ST_HOLD: begin
        if (ph_zero) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign ph_dec = ((state == ST_SETUP) || (state == ST_HOLD)) && !ph_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_addr  <= '0;
      cur_wdata <= '0;
      cur_wide  <= 1'b0;
      cur_io    <= 1'b0;
      cur_write <= 1'b0;
      cur_lock  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      state     <= state_n;
      rsp_valid <= rsp_fire;
      if (accept) begin
        cur_addr  <= req_addr;
        cur_wdata <= req_wdata;
        cur_wide  <= req_wide;
        cur_io    <= req_io;
        cur_write <= req_write;
        cur_lock  <= req_lock;
      end
      if (rsp_fire) begin
        rsp_err   <= rsp_err_n;
        rsp_rdata <= (cur_write || rsp_err_n) ? '0 : rd_true;
      end
    end
  end

  // bus line decode from registered state
  assign drive  = (state == ST_SETUP) || (state == ST_CMD);
  assign cmd_on = (state == ST_CMD);

  assign wd_lanes = cur_wide ? cur_wdata
                             : {{(DATA_W-LANE_W){1'b0}}, cur_wdata[LANE_W-1:0]};

  assign bus_adr_oe    = drive;
  assign bus_adr_n     = drive ? ~cur_addr : '1;
  assign bus_bhe_n     = !(drive && cur_wide);
  assign bus_dat_oe    = drive && cur_write;
  assign bus_dat_out_n = bus_dat_oe ? ~wd_lanes : '1;
  assign bus_lock_n    = !lk_on;

  assign sel = strobe_sel(cur_io, cur_write);

  for (genvar g = 0; g < STROBE_N; g++) begin : g_strobe
    assign strobe_n[g] = !(cmd_on && sel[g]);
  end

  assign bus_mrd_n = strobe_n[SI_MRD];
  assign bus_mwr_n = strobe_n[SI_MWR];
  assign bus_ior_n = strobe_n[SI_IOR];
  assign bus_iow_n = strobe_n[SI_IOW];
endmodule

// File: rtl/bxm_checker.sv
module bxm_checker #(
  parameter int ADDR_W       = 24,
  parameter int DATA_W       = 16,
  parameter int SETUP_CYC    = 3,
  parameter int TIMEOUT_CYC  = 50000,
  parameter int LOCK_MAX_CYC = 600
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              lock_abort,
  input logic [ADDR_W-1:0] bus_adr_n,
  input logic              bus_adr_oe,
  input logic              bus_bhe_n,
  input logic [DATA_W-1:0] bus_dat_out_n,
  input logic              bus_dat_oe,
  input logic              bus_mrd_n,
  input logic              bus_mwr_n,
  input logic              bus_ior_n,
  input logic              bus_iow_n,
  input logic              bus_lock_n
);
  logic        cmd_on;
  logic [31:0] setup_cnt, cmd_cnt, lock_cnt;

  assign cmd_on = !(bus_mrd_n && bus_mwr_n && bus_ior_n && bus_iow_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_cnt <= '0;
      cmd_cnt   <= '0;
      lock_cnt  <= '0;
    end else begin
      if (!bus_adr_oe)  setup_cnt <= '0;
      else if (!cmd_on) setup_cnt <= setup_cnt + 1;
      cmd_cnt  <= cmd_on ? cmd_cnt + 1 : '0;
      lock_cnt <= !bus_lock_n ? lock_cnt + 1 : '0;
    end
  end

  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~bus_mrd_n, ~bus_mwr_n, ~bus_ior_n, ~bus_iow_n}) <= 1);

  // R2
  adr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_on && $past(cmd_on)) |-> ($stable(bus_adr_n) && $stable(bus_bhe_n)));

  // R2
  setup_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_on) |-> (setup_cnt == SETUP_CYC));

  // R4
  narrow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dat_oe && bus_bhe_n) |-> (&bus_dat_out_n[DATA_W-1:DATA_W/2]));

  // R6
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R6
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_on || bus_adr_oe) |-> !req_ready);

  // R7
  cmd_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cnt <= TIMEOUT_CYC);

  // R10
  lock_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_cnt <= LOCK_MAX_CYC);

  // R10
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_abort |-> bus_lock_n);
endmodule

bind bus_xfer_master bxm_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC),
  .TIMEOUT_CYC(TIMEOUT_CYC), .LOCK_MAX_CYC(LOCK_MAX_CYC)
) u_bxm_checker (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .lock_abort(lock_abort), .bus_adr_n(bus_adr_n), .bus_adr_oe(bus_adr_oe),
  .bus_bhe_n(bus_bhe_n), .bus_dat_out_n(bus_dat_out_n), .bus_dat_oe(bus_dat_oe),
  .bus_mrd_n(bus_mrd_n), .bus_mwr_n(bus_mwr_n), .bus_ior_n(bus_ior_n),
  .bus_iow_n(bus_iow_n), .bus_lock_n(bus_lock_n)
);

// File: tb/tb_bus_xfer_master.sv
`timescale 1ns/1ps
module tb_bus_xfer_master;
  localparam int SETUP = 3;
  localparam int HOLD  = 5;
  localparam int TMO   = 50000;
  localparam int LMAX  = 600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_wide = 1'b0, req_io = 1'b0, req_write = 1'b0, req_lock = 1'b0;
  logic        rsp_valid, rsp_err, lock_abort;
  logic [15:0] rsp_rdata;
  logic [23:0] bus_adr_n;
  logic        bus_adr_oe, bus_bhe_n, bus_dat_oe;
  logic [15:0] bus_dat_out_n;
  logic [15:0] bus_dat_in_n = 16'hFFFF;
  logic        bus_mrd_n, bus_mwr_n, bus_ior_n, bus_iow_n;
  logic        bus_ack_n = 1'b1;
  logic        bus_lock_n;

  always #10 clk = ~clk;  // 50 MHz

  bus_xfer_master #(
    .SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .TIMEOUT_CYC(TMO), .LOCK_MAX_CYC(LMAX)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_wide(req_wide),
    .req_io(req_io), .req_write(req_write), .req_lock(req_lock),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .lock_abort(lock_abort), .bus_adr_n(bus_adr_n), .bus_adr_oe(bus_adr_oe),
    .bus_bhe_n(bus_bhe_n), .bus_dat_out_n(bus_dat_out_n), .bus_dat_oe(bus_dat_oe),
    .bus_dat_in_n(bus_dat_in_n), .bus_mrd_n(bus_mrd_n), .bus_mwr_n(bus_mwr_n),
    .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n), .bus_ack_n(bus_ack_n),
    .bus_lock_n(bus_lock_n)
  );

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  // slave model and monitor state
  logic        sl_en = 1'b1;
  int          sl_delay = 2, sl_hold = 0;
  logic [15:0] sl_rdata = '0;
  int          wait_cnt = 0, hold_cnt = 0;
  logic        prev_cmd = 1'b0;
  int          run_setup = 0, seen_setup = 0;
  logic [3:0]  seen_kind = '0;
  logic [23:0] seen_adr = '0;
  logic        seen_bhe_n = 1'b1, seen_lock = 1'b0;
  logic [15:0] seen_dat = '0;
  int          cmd_len = 0, last_cmd_len = 0, since_end = 0;
  int          lock_run = 0, last_lock_len = 0, lock_gap = 0;
  int          abort_cnt = 0, rsp_cnt = 0;
  logic [15:0] rsp_d = '0;
  logic        rsp_e = 1'b0;

  always @(negedge clk) begin
    logic cmd_low;
    cmd_low = !(bus_mrd_n && bus_mwr_n && bus_ior_n && bus_iow_n);
    if (bus_adr_oe && !cmd_low) run_setup++;
    if (cmd_low && !prev_cmd) begin
      seen_setup = run_setup;
      seen_kind  = {~bus_iow_n, ~bus_ior_n, ~bus_mwr_n, ~bus_mrd_n};
      seen_adr   = ~bus_adr_n;
      seen_bhe_n = bus_bhe_n;
      seen_dat   = bus_dat_oe ? ~bus_dat_out_n : 16'h0;
      seen_lock  = !bus_lock_n;
      cmd_len    = 0;
    end
    if (!bus_adr_oe) run_setup = 0;
    if (cmd_low) cmd_len++;
    if (!cmd_low && prev_cmd) begin
      last_cmd_len = cmd_len;
      since_end = 0;
    end else begin
      since_end++;
    end
    if (!bus_lock_n) lock_run++;
    else if (lock_run != 0) begin
      last_lock_len = lock_run;
      lock_gap = since_end;
      lock_run = 0;
    end
    if (lock_abort) abort_cnt++;
    if (rsp_valid) begin
      rsp_cnt++;
      rsp_d = rsp_rdata;
      rsp_e = rsp_err;
    end
    if (cmd_low && sl_en && bus_ack_n) begin
      if (wait_cnt >= sl_delay) begin
        bus_ack_n = 1'b0;
        bus_dat_in_n = ~sl_rdata;
      end else wait_cnt++;
    end
    if (!cmd_low) wait_cnt = 0;
    if (!cmd_low && !bus_ack_n) begin
      if (hold_cnt >= sl_hold) begin
        bus_ack_n = 1'b1;
        bus_dat_in_n = 16'hFFFF;
        hold_cnt = 0;
      end else hold_cnt++;
    end
    prev_cmd = cmd_low;
  end

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [23:0] a, input logic [15:0] d,
                      input logic wide, input logic io, input logic wr, input logic lk);
    req_addr = a; req_wdata = d; req_wide = wide;
    req_io = io; req_write = wr; req_lock = lk;
    req_valid = 1'b1;
    while (!req_ready) step();
    step();
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(input int n0, input int limit);
    for (int k = 0; k < limit && rsp_cnt == n0; k++) step();
  endtask

  task automatic t_reset();
    chk("R1 adr idle", {8'h0, bus_adr_n}, 32'hFFFFFF);
    chk("R1 strobes idle", {bus_mrd_n, bus_mwr_n, bus_ior_n, bus_iow_n}, 4'hF);
    chk("R1 bhe/lock idle", {bus_bhe_n, bus_lock_n}, 2'b11);
    chk("R1 data idle", bus_dat_out_n, 16'hFFFF);
    chk("R1 enables", {bus_adr_oe, bus_dat_oe}, 2'b00);
    chk("R1 ready/rsp", {req_ready, rsp_valid}, 2'b10);
  endtask

  task automatic t_mem_read16();
    int n0 = rsp_cnt;
    sl_rdata = 16'hBEEF; sl_delay = 2;
    send(24'hA51234, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    wait_rsp(n0, 200);
    chk("R2 setup cycles", seen_setup, SETUP);
    chk("R2 address", seen_adr, 24'hA51234);
    chk("R3 mem read strobe", seen_kind, 4'b0001);
    chk("R4 wide bhe low", seen_bhe_n, 1'b0);
    chk("R5 read data", rsp_d, 16'hBEEF);
    chk("R5 no error", rsp_e, 1'b0);
  endtask

  task automatic t_mem_write8();
    int n0 = rsp_cnt;
    send(24'h00FFFE, 16'h12AB, 1'b0, 1'b0, 1'b1, 1'b0);
    wait_rsp(n0, 200);
    chk("R3 mem write strobe", seen_kind, 4'b0010);
    chk("R4 narrow bhe high", seen_bhe_n, 1'b1);
    chk("R4 narrow write lanes", seen_dat, 16'h00AB);
    chk("R2 address", seen_adr, 24'h00FFFE);
    chk("R5 write ok", rsp_e, 1'b0);
  endtask

  task automatic t_io_read8();
    int n0 = rsp_cnt;
    sl_rdata = 16'hFFC3;
    send(24'h000081, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    wait_rsp(n0, 200);
    chk("R3 io read strobe", seen_kind, 4'b0100);
    chk("R4 narrow read mask", rsp_d, 16'h00C3);
  endtask

  task automatic t_io_write16();
    int n0 = rsp_cnt;
    send(24'h5A0003, 16'h5A5A, 1'b1, 1'b1, 1'b1, 1'b0);
    wait_rsp(n0, 200);
    chk("R3 io write strobe", seen_kind, 4'b1000);
    chk("R4 wide write data", seen_dat, 16'h5A5A);
    chk("R4 wide bhe low", seen_bhe_n, 1'b0);
  endtask

  task automatic t_ack_recovery();
    int n0 = rsp_cnt;
    int waited = 0;
    sl_hold = 8;
    send(24'h000200, 16'h0001, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R6 busy after accept", req_ready, 1'b0);
    wait_rsp(n0, 200);
    chk("R6 one response", rsp_cnt, n0 + 1);
    step(); step(); step();
    chk("R6 ack still low", bus_ack_n, 1'b0);
    chk("R6 ready held low", req_ready, 1'b0);
    chk("R6 single pulse", rsp_valid, 1'b0);
    while (!req_ready && waited < 100) begin step(); waited++; end
    chk("R6 ready after ack release", req_ready, 1'b1);
    chk("R6 ack released", bus_ack_n, 1'b1);
    sl_hold = 0;
  endtask

  task automatic t_timeout();
    int n0 = rsp_cnt;
    sl_en = 1'b0;
    send(24'h300000, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    wait_rsp(n0, TMO + 200);
    chk("R7 timeout error", rsp_e, 1'b1);
    chk("R7 strobe length", last_cmd_len, TMO);
    chk("R7 strobes released", {bus_mrd_n, bus_mwr_n, bus_ior_n, bus_iow_n}, 4'hF);
    sl_en = 1'b1;
  endtask

  task automatic t_locked_rmw();
    int n0 = rsp_cnt;
    int a0 = abort_cnt;
    sl_rdata = 16'h1234;
    send(24'h000100, 16'h0, 1'b1, 1'b0, 1'b0, 1'b1);
    wait_rsp(n0, 200);
    chk("R8 lock before read strobe", seen_lock, 1'b1);
    chk("R5 locked read data", rsp_d, 16'h1234);
    for (int k = 0; k < 10; k++) step();
    chk("R8 lock held between", bus_lock_n, 1'b0);
    send(24'h000100, 16'h1235, 1'b1, 1'b0, 1'b1, 1'b0);
    wait_rsp(n0 + 1, 200);
    chk("R9 final write locked", seen_lock, 1'b1);
    for (int k = 0; k < 40 && !bus_lock_n; k++) step();
    chk("R9 lock released", bus_lock_n, 1'b1);
    chk("R9 tail hold", (lock_gap >= HOLD) ? 1 : 0, 1);
    chk("R10 no abort", abort_cnt, a0);
  endtask

  task automatic t_lock_idle_expire();
    int n0 = rsp_cnt;
    int a0 = abort_cnt;
    sl_rdata = 16'h0042;
    send(24'h000400, 16'h0, 1'b1, 1'b0, 1'b0, 1'b1);
    wait_rsp(n0, 200);
    for (int k = 0; k < LMAX + 50 && !bus_lock_n; k++) step();
    step();
    chk("R10 idle lock length", last_lock_len, LMAX);
    chk("R10 idle abort pulse", abort_cnt, a0 + 1);
    chk("R10 no extra response", rsp_cnt, n0 + 1);
    chk("R10 ready after abort", req_ready, 1'b1);
  endtask

  task automatic t_lock_stuck_expire();
    int n0 = rsp_cnt;
    int a0 = abort_cnt;
    sl_delay = 1000;
    send(24'h000800, 16'h0, 1'b1, 1'b0, 1'b0, 1'b1);
    wait_rsp(n0, LMAX + 100);
    step();
    chk("R10 stuck abort error", rsp_e, 1'b1);
    chk("R10 stuck abort pulse", abort_cnt, a0 + 1);
    chk("R10 stuck lock length", last_lock_len, LMAX);
    chk("R10 strobe released", {bus_mrd_n, bus_mwr_n, bus_ior_n, bus_iow_n}, 4'hF);
    sl_delay = 2;
    for (int k = 0; k < 10; k++) step();
  endtask

  initial begin
    for (int k = 0; k < 190000 && !done; k++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) step();
    t_reset();
    rst_n = 1'b1;
    step(); step();
    t_reset();
    t_mem_read16();
    t_mem_write8();
    t_io_read8();
    t_io_write16();
    t_ack_recovery();
    t_timeout();
    t_locked_rmw();
    t_lock_idle_expire();
    t_lock_stuck_expire();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule